// File: doc/BRIEF.md
# Register Rename Map with Free List

This block turns the architectural register numbers of one instruction per cycle into physical register tags. Every instruction that writes a register receives a fresh physical tag from a pool of unused tags. The map entry for that architectural register then points at the new tag. Write-after-read and write-after-write conflicts between instructions therefore vanish. A later reader of the same register still gets the producer's tag, so true data dependences are kept.

The pool of unused tags is a circular FIFO. Tags are handed out from its head. Tags returned on the release port are appended at its tail. A release and an allocation in the same cycle are both carried out. When an instruction needs a destination and the pool is empty, the block raises a stall in that same cycle and takes nothing in. The block handles tags only: operand values, commit order and recovery are left to the blocks around it.

Top module: `reg_rename_map`

## Requirements
- R1: Reset (synchronous, active high) state. Architectural register N (1..NUM_ARCH) maps to physical tag N. The free pool holds tags NUM_ARCH+1 .. NUM_PHYS, lowest at the head. `stall` is 0.
- R2: A source operand's tag is the map entry as it stood before the same instruction's destination update. An instruction reading and writing the same register sees the old tag.
- R3: A destination takes the tag at the head of the free pool. The map entry is overwritten, so later instructions reading that register see the new tag. The sequence dst1←r2,r3; dst3←r2,r1; dst3←r2,r3; dst1←r1,imm after reset renames to 2,3→4; 2,4→5; 2,5→6; 4,imm→7.
- R4: A source whose immediate flag is 1 is not looked up. Its `src*_is_reg` output is 0 and its tag output is 0. A register source has `is_reg` = 1.
- R5: Destination field 0 means "no destination". Such an instruction takes no tag, never stalls, leaves the map unchanged, and has `out_dst_valid` = 0.
- R6: When `in_valid` is 1, the destination is non-zero and the free pool is empty, `stall` is 1 and the instruction is dropped. `out_valid` is 0 in the next cycle, and the map and pool are unchanged.
- R7: A released tag is appended at the tail of the pool. It is handed out only after every tag already in the pool. A release and an allocation in the same cycle both take effect, with the allocation taking the old head.
- R8: An instruction accepted at a clock edge shows up on the registered outputs right after that edge, with `out_valid` = 1 for exactly one cycle.
- R9: `stall` depends on the current inputs and the pool state before this cycle's release. A release in the same cycle does not lift a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_dst | input | AW | Destination architectural register, 0 = none |
| in_src1 | input | AW | First source architectural register |
| in_src1_imm | input | 1 | First source is an immediate |
| in_src2 | input | AW | Second source architectural register |
| in_src2_imm | input | 1 | Second source is an immediate |
| rel_valid | input | 1 | Return a tag to the free pool |
| rel_tag | input | PW | Tag being returned |
| stall | output | 1 | Instruction cannot be accepted this cycle |
| out_valid | output | 1 | Renamed instruction present |
| out_src1_tag | output | PW | Renamed first source |
| out_src1_is_reg | output | 1 | First source is a register |
| out_src2_tag | output | PW | Renamed second source |
| out_src2_is_reg | output | 1 | Second source is a register |
| out_dst_valid | output | 1 | A destination tag was allocated |
| out_dst_tag | output | PW | Allocated destination tag |

## Verification
A corrupted map entry shows up on the very next instruction that reads that architectural register. The tag on that instruction's source output, one cycle after issue, differs from the model. A wrong pool pointer or count shows up at the next allocation as an out-of-order destination tag, or as a stall that comes too early or too late. The bench follows every instruction with reads that expose the map, and it drains the pool to its limit so that both kinds of fault reach the ports within a few cycles.

// File: rtl/rename_pkg.sv
package rename_pkg;

  typedef enum logic {
    OPND_IMM = 1'b0,
    OPND_REG = 1'b1
  } opnd_kind_e;

  localparam int NUM_SRC = 2;

  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = 3,
  parameter int AW       = 2,
  parameter int PW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_addr,
  output logic [PW-1:0] rd_a_tag,
  input  logic [AW-1:0] rd_b_addr,
  output logic [PW-1:0] rd_b_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [PW-1:0] wr_tag
);
  localparam int ENTRIES = 1 << AW;

  logic [PW-1:0] map_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        map_q[i] <= (i <= NUM_ARCH) ? PW'(i) : '0;
      end
    end else if (wr_en) begin
      map_q[wr_addr] <= wr_tag;
    end
  end

  // reads see the table before this cycle's write
  assign rd_a_tag = map_q[rd_a_addr];
  assign rd_b_tag = map_q[rd_b_addr];

  // R5
  no_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr != '0);

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> map_q[$past(wr_addr)] == $past(wr_tag));

  // R1
  reset_identity_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> map_q[1] == PW'(1));

endmodule

// File: rtl/rename_free_fifo.sv
module rename_free_fifo
  import rename_pkg::*;
#(
  parameter int FIRST_TAG = 4,
  parameter int DEPTH     = 4,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] head_tag,
  output logic          empty,
  output logic          full
);
  localparam int PTRW = ptr_width(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);

  logic [PW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0]   cnt;
  logic            push_ok;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign push_ok  = push && (!full || pop);
  assign head_tag = mem[rd_ptr];

  function automatic logic [PTRW-1:0] wrap_inc(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= PW'(FIRST_TAG + i);
      end
    end else if (push_ok) begin
      mem[wr_ptr] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= CW'(DEPTH);
    end else begin
      if (pop)     rd_ptr <= wrap_inc(rd_ptr);
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R7
  pop_only_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> cnt == $past(cnt) - 1'b1);

  // R7
  both_keep_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && push) |=> cnt == $past(cnt));

  // R1
  reset_full_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cnt == CW'(DEPTH));

endmodule

// File: rtl/rename_src_port.sv
module rename_src_port
  import rename_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          is_imm,
  input  logic [PW-1:0] map_tag,
  output logic [PW-1:0] tag,
  output opnd_kind_e    kind
);
  always_comb begin
    if (is_imm) begin
      tag  = '0;
      kind = OPND_IMM;
    end else begin
      tag  = map_tag;
      kind = OPND_REG;
    end
  end
endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 3,
  parameter int NUM_PHYS = 7,
  parameter int AW       = $clog2(NUM_ARCH + 1),
  parameter int PW       = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_src1,
  input  logic          in_src1_imm,
  input  logic [AW-1:0] in_src2,
  input  logic          in_src2_imm,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  output logic          stall,
  output logic          out_valid,
  output logic [PW-1:0] out_src1_tag,
  output logic          out_src1_is_reg,
  output logic [PW-1:0] out_src2_tag,
  output logic          out_src2_is_reg,
  output logic          out_dst_valid,
  output logic [PW-1:0] out_dst_tag
);
  localparam int DEPTH = NUM_PHYS - NUM_ARCH;

  logic          need_dst, accept, alloc, pool_empty, pool_full;
  logic [PW-1:0] head_tag;
  logic [PW-1:0] map_tag  [NUM_SRC];
  logic          src_imm  [NUM_SRC];
  logic [PW-1:0] src_tag  [NUM_SRC];
  opnd_kind_e    src_kind [NUM_SRC];

  assign need_dst = (in_dst != '0);
  assign stall    = in_valid && need_dst && pool_empty;
  assign accept   = in_valid && !stall;
  assign alloc    = accept && need_dst;

  assign src_imm[0] = in_src1_imm;
  assign src_imm[1] = in_src2_imm;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .AW(AW), .PW(PW)) u_map (
    .clk      (clk),
    .rst      (rst),
    .rd_a_addr(in_src1),
    .rd_a_tag (map_tag[0]),
    .rd_b_addr(in_src2),
    .rd_b_tag (map_tag[1]),
    .wr_en    (alloc),
    .wr_addr  (in_dst),
    .wr_tag   (head_tag)
  );

  rename_free_fifo #(.FIRST_TAG(NUM_ARCH + 1), .DEPTH(DEPTH), .PW(PW)) u_pool (
    .clk     (clk),
    .rst     (rst),
    .pop     (alloc),
    .push    (rel_valid),
    .push_tag(rel_tag),
    .head_tag(head_tag),
    .empty   (pool_empty),
    .full    (pool_full)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rename_src_port #(.PW(PW)) u_src (
      .is_imm (src_imm[s]),
      .map_tag(map_tag[s]),
      .tag    (src_tag[s]),
      .kind   (src_kind[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_src1_tag    <= '0;
      out_src1_is_reg <= 1'b0;
      out_src2_tag    <= '0;
      out_src2_is_reg <= 1'b0;
      out_dst_valid   <= 1'b0;
      out_dst_tag     <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src1_tag    <= src_tag[0];
        out_src1_is_reg <= (src_kind[0] == OPND_REG);
        out_src2_tag    <= src_tag[1];
        out_src2_is_reg <= (src_kind[1] == OPND_REG);
        out_dst_valid   <= need_dst;
        out_dst_tag     <= need_dst ? head_tag : '0;
      end
    end
  end

  // R6
  stall_drops_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_valid);

  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !stall) |=> out_valid);

  // R4
  imm_zero_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_src1_is_reg) |-> out_src1_tag == '0);

  // R3
  dst_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_valid) |-> out_dst_tag != '0);

  // R9
  full_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    pool_full |-> !stall);

endmodule

// File: tb/sim_reg_rename_map.sv
module sim_reg_rename_map;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 3;
  localparam int NP = 7;
  localparam int AW = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_src1_imm = 1'b0, in_src2_imm = 1'b0, rel_valid = 1'b0;
  logic [AW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [PW-1:0] rel_tag = '0;
  logic stall, out_valid, out_src1_is_reg, out_src2_is_reg, out_dst_valid;
  logic [PW-1:0] out_src1_tag, out_src2_tag, out_dst_tag;

  int checks = 0;
  int errors = 0;
  int map_m [NA+1];
  int pool_m [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_rename_map #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
    .in_src1(in_src1), .in_src1_imm(in_src1_imm),
    .in_src2(in_src2), .in_src2_imm(in_src2_imm),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .stall(stall),
    .out_valid(out_valid), .out_src1_tag(out_src1_tag),
    .out_src1_is_reg(out_src1_is_reg), .out_src2_tag(out_src2_tag),
    .out_src2_is_reg(out_src2_is_reg), .out_dst_valid(out_dst_valid),
    .out_dst_tag(out_dst_tag)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: optional instruction plus optional release, checked against the model.
  task automatic step(input string req, input bit v, input int dst, input int s1, input bit i1,
                      input int s2, input bit i2, input bit rv, input int rt);
    bit exp_stall;
    int e1, e2, ed;
    @(negedge clk);
    in_valid = v; in_dst = AW'(dst); in_src1 = AW'(s1); in_src1_imm = i1;
    in_src2 = AW'(s2); in_src2_imm = i2; rel_valid = rv; rel_tag = PW'(rt);
    exp_stall = v && (dst != 0) && (pool_m.size() == 0);
    e1 = i1 ? 0 : map_m[s1];
    e2 = i2 ? 0 : map_m[s2];
    ed = 0;
    #1;
    check_eq(req, "stall", int'(stall), int'(exp_stall));
    if (v && !exp_stall && dst != 0) begin
      ed = pool_m.pop_front();
      map_m[dst] = ed;
    end
    if (rv) pool_m.push_back(rt);
    @(negedge clk);
    in_valid = 1'b0; rel_valid = 1'b0;
    check_eq(req, "out_valid", int'(out_valid), int'(v && !exp_stall));
    if (v && !exp_stall) begin
      check_eq(req, "src1_tag", int'(out_src1_tag), e1);
      check_eq(req, "src1_is_reg", int'(out_src1_is_reg), int'(!i1));
      check_eq(req, "src2_tag", int'(out_src2_tag), e2);
      check_eq(req, "src2_is_reg", int'(out_src2_is_reg), int'(!i2));
      check_eq(req, "dst_valid", int'(out_dst_valid), int'(dst != 0));
      if (dst != 0) check_eq(req, "dst_tag", int'(out_dst_tag), ed);
    end
  endtask

  // R1: identity map and idle outputs after reset
  task automatic t_reset_state();
    @(negedge clk);
    check_eq("R1", "stall after reset", int'(stall), 0);
    check_eq("R1", "out_valid after reset", int'(out_valid), 0);
    step("R1", 1, 0, 1, 0, 2, 0, 0, 0);
    step("R1", 1, 0, 3, 0, 3, 1, 0, 0);
  endtask

  // R2 R3 R4: the four-instruction rename example
  task automatic t_example();
    step("R3", 1, 1, 2, 0, 3, 0, 0, 0);
    check_eq("R3", "add dst literal", int'(out_dst_tag), 4);
    step("R3", 1, 3, 2, 0, 1, 0, 0, 0);
    check_eq("R3", "sub src2 literal", int'(out_src2_tag), 4);
    step("R2", 1, 3, 2, 0, 3, 0, 0, 0);
    check_eq("R2", "mul src2 old tag", int'(out_src2_tag), 5);
    step("R4", 1, 1, 1, 0, 0, 1, 0, 0);
    check_eq("R4", "div dst literal", int'(out_dst_tag), 7);
  endtask

  // R6 R9 R5: empty pool stalls, even with a release that cycle; map untouched
  task automatic t_stall_empty();
    step("R6", 1, 2, 1, 0, 2, 0, 0, 0);
    step("R9", 1, 3, 1, 0, 1, 0, 1, 1);
    step("R5", 1, 0, 2, 0, 3, 0, 0, 0);
    check_eq("R6", "map r2 unchanged", int'(out_src1_tag), 2);
  endtask

  // R7: released tags reused in order; release and allocate together
  task automatic t_release_order();
    step("R7", 0, 0, 0, 0, 0, 0, 1, 4);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 5);
    step("R7", 1, 2, 2, 0, 3, 0, 1, 2);
    check_eq("R7", "first release reused first", int'(out_dst_tag), 1);
    step("R7", 1, 3, 2, 0, 3, 0, 0, 0);
    step("R7", 1, 2, 2, 0, 3, 0, 0, 0);
    step("R7", 1, 1, 2, 0, 1, 0, 0, 0);
    check_eq("R7", "same-cycle release honoured", int'(out_dst_tag), 2);
    step("R6", 1, 1, 3, 0, 2, 0, 0, 0);
  endtask

  // R5 R8: no-destination instructions keep the pool; single-cycle out_valid
  task automatic t_no_dst();
    step("R5", 0, 0, 0, 0, 0, 0, 1, 7);
    step("R5", 1, 0, 1, 0, 2, 0, 0, 0);
    step("R5", 1, 0, 3, 1, 3, 1, 0, 0);
    step("R8", 1, 3, 3, 0, 1, 0, 0, 0);
    check_eq("R5", "pool kept tag", int'(out_dst_tag), 7);
    @(negedge clk);
    check_eq("R8", "out_valid one cycle", int'(out_valid), 0);
  endtask

  initial begin
    for (int i = 0; i <= NA; i++) map_m[i] = i;
    for (int t = NA + 1; t <= NP; t++) pool_m.push_back(t);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_example();
    t_stall_empty();
    t_release_order();
    t_no_dst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule